// File: doc/BRIEF.md
# Instruction Length Pre-Decoder

This block looks at the leading halfword of an instruction in a big-endian instruction byte stream and reports how long the instruction is, ahead of the full decoder. The major opcode is the top six bits of that halfword. The halfword's most significant bit is opcode bit 0, so `hw_i[15:10]` carries the opcode.

When the escape enable is set, the opcode row whose three upper opcode bits are all zero is given over to length selection. The next two opcode bits, `hw_i[12:11]`, choose the length class. The eleven bits that follow, `hw_i[10:0]`, are handed on as payload. Every other opcode, and every opcode at all while escape is off, is a plain 32-bit instruction.

Results are registered and appear one clock after the input strobe. The class is one-hot, and a byte count comes with it. A variable-length block reports a byte count of zero, and a later stage decodes its real size.

Top module: `ilen_predec`

## Requirements
- R1: While `rst_ni` is low and after its release with no strobe, `valid_o`, `class_o`, `len_o` and `payload_o` are all zero.
- R2: `valid_o` equals the `valid_i` sampled at the previous rising clock edge.
- R3: With escape on, `hw_i[15:13]==0` and `hw_i[12:11]==2'b00`, the next cycle shows `class_o==5'b00001` (compressed) and `len_o==2`.
- R4: With escape on, `hw_i[15:13]==0` and `hw_i[12:11]==2'b01`, the next cycle shows `class_o==5'b00100` (48-bit prefixed) and `len_o==6`.
- R5: With escape on, `hw_i[15:13]==0` and `hw_i[12:11]==2'b10`, the next cycle shows `class_o==5'b01000` (64-bit prefixed) and `len_o==8`.
- R6: With escape on, `hw_i[15:13]==0` and `hw_i[12:11]==2'b11`, the next cycle shows `class_o==5'b10000` (variable-length block) and `len_o==0`.
- R7: A strobed halfword with `hw_i[15:13]!=0` gives `class_o==5'b00010` (plain 32-bit) and `len_o==4`, whatever the escape enable is.
- R8: With `esc_en_i` low, every strobed halfword gives `class_o==5'b00010` and `len_o==4`. This includes the `hw_i[15:13]==0` row.
- R9: `payload_o` carries `hw_i[10:0]` for the four escape classes and is zero for the plain 32-bit class.
- R10: A cycle without a strobe gives zero on `class_o`, `len_o` and `payload_o` in the next cycle. A strobed cycle gives exactly one set bit in `class_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Halfword strobe |
| esc_en_i | input | 1 | Escape mode enable |
| hw_i | input | HW_W (16) | Leading instruction halfword, big-endian order |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| class_o | output | 5 | One-hot class: bit0 compressed, bit1 32-bit, bit2 48-bit, bit3 64-bit, bit4 variable block |
| len_o | output | 4 | Byte length: 2, 4, 6, 8, or 0 for the variable block |
| payload_o | output | PAY_W (11) | Bits after the selecting prefix |

## Verification
The bench builds the block with its default parameters: a 16-bit halfword, a three-bit row field and a two-bit selector, which leaves an 11-bit payload. All 64 major opcodes are swept with escape on and again with escape off. This covers each row pair, the boundary between the 000 row and its neighbours, and the legacy fallback. Mixed payload patterns and gaps without a strobe exercise the zeroing of the payload and the class.

// File: rtl/ilen_pkg.sv
package ilen_pkg;
  localparam int NUM_CLS   = 5;
  localparam int CLS_IDX_W = 3;
  localparam int LEN_W     = 4;

  typedef logic [CLS_IDX_W-1:0] cls_idx_t;

  localparam cls_idx_t CLS_C16 = 3'd0;
  localparam cls_idx_t CLS_W32 = 3'd1;
  localparam cls_idx_t CLS_P48 = 3'd2;
  localparam cls_idx_t CLS_P64 = 3'd3;
  localparam cls_idx_t CLS_VBK = 3'd4;

  // selector pair -> class; order is fixed by the opcode row
  function automatic cls_idx_t cls_of_sel(input int sel);
    case (sel)
      0:       return CLS_C16;
      1:       return CLS_P48;
      2:       return CLS_P64;
      3:       return CLS_VBK;
      default: return CLS_W32;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] len_of_cls(input cls_idx_t c);
    case (c)
      CLS_C16: return 4'd2;
      CLS_W32: return 4'd4;
      CLS_P48: return 4'd6;
      CLS_P64: return 4'd8;
      default: return 4'd0; // variable block resolved downstream
    endcase
  endfunction
endpackage

// File: rtl/ilen_row_match.sv
module ilen_row_match #(
  parameter int HW_W  = 16,
  parameter int ROW_W = 3,
  parameter int SEL_W = 2
) (
  input  logic [HW_W-1:0]  hw_i,
  input  logic             esc_en_i,
  output logic             in_row_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam int ROW_HI = HW_W - 1;
  localparam int ROW_LO = HW_W - ROW_W;
  localparam int SEL_LO = ROW_LO - SEL_W;

  assign in_row_o = esc_en_i && (hw_i[ROW_HI:ROW_LO] == '0);
  assign sel_o    = hw_i[ROW_LO-1:SEL_LO];
endmodule

// File: rtl/ilen_class_dec.sv
module ilen_class_dec
  import ilen_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic               valid_i,
  input  logic               in_row_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [NUM_CLS-1:0] cls_o
);
  localparam int NUM_SEL = 1 << SEL_W;

  logic [NUM_SEL-1:0] hit;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_hit
    assign hit[g] = in_row_i && (sel_i == SEL_W'(g));
  end

  always_comb begin
    cls_o = '0;
    if (valid_i) begin
      if (!in_row_i) cls_o[CLS_W32] = 1'b1;
      for (int s = 0; s < NUM_SEL; s++)
        if (hit[s]) cls_o[cls_of_sel(s)] = 1'b1;
    end
  end
endmodule

// File: rtl/ilen_len_enc.sv
module ilen_len_enc
  import ilen_pkg::*;
(
  input  logic [NUM_CLS-1:0] cls_i,
  output logic [LEN_W-1:0]   len_o
);
  always_comb begin
    len_o = '0;
    for (int i = 0; i < NUM_CLS; i++)
      if (cls_i[i]) len_o = len_o | len_of_cls(cls_idx_t'(i));
  end
endmodule

// File: rtl/ilen_predec.sv
module ilen_predec
  import ilen_pkg::*;
#(
  parameter int HW_W  = 16,
  parameter int ROW_W = 3,
  parameter int SEL_W = 2,
  localparam int PAY_W = HW_W - ROW_W - SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               esc_en_i,
  input  logic [HW_W-1:0]    hw_i,
  output logic               valid_o,
  output logic [NUM_CLS-1:0] class_o,
  output logic [LEN_W-1:0]   len_o,
  output logic [PAY_W-1:0]   payload_o
);
  logic               in_row;
  logic [SEL_W-1:0]   sel;
  logic [NUM_CLS-1:0] cls_d;
  logic [LEN_W-1:0]   len_d;
  logic [PAY_W-1:0]   pay_d;

  ilen_row_match #(.HW_W(HW_W), .ROW_W(ROW_W), .SEL_W(SEL_W)) u_row (
    .hw_i     (hw_i),
    .esc_en_i (esc_en_i),
    .in_row_o (in_row),
    .sel_o    (sel)
  );

  ilen_class_dec #(.SEL_W(SEL_W)) u_cls (
    .valid_i  (valid_i),
    .in_row_i (in_row),
    .sel_i    (sel),
    .cls_o    (cls_d)
  );

  ilen_len_enc u_len (
    .cls_i (cls_d),
    .len_o (len_d)
  );

  assign pay_d = (valid_i && in_row) ? hw_i[PAY_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      class_o   <= '0;
      len_o     <= '0;
      payload_o <= '0;
    end else begin
      valid_o   <= valid_i;
      class_o   <= cls_d;
      len_o     <= len_d;
      payload_o <= pay_d;
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (class_o == '0 && len_o == '0 && payload_o == '0));
  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(class_o) == 1);
  p_c16_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_o[CLS_C16] |-> len_o == 4'd2);
  p_p48_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_o[CLS_P48] |-> len_o == 4'd6);
  p_p64_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_o[CLS_P64] |-> len_o == 4'd8);
  p_vbk_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_o[CLS_VBK] |-> len_o == 4'd0);
  p_outside_row_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hw_i[HW_W-1 -: ROW_W] != '0) |=> class_o[CLS_W32]);
  p_esc_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !esc_en_i) |=> (class_o[CLS_W32] && len_o == 4'd4));
  p_w32_pay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_o[CLS_W32] |-> payload_o == '0);
endmodule

// File: tb/ilen_predec_bench.sv
module ilen_predec_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        v;
    logic [4:0]  cls;
    logic [3:0]  len;
    logic [10:0] pay;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        esc = 1'b0;
  logic [15:0] hw = '0;
  logic        valid_o;
  logic [4:0]  class_o;
  logic [3:0]  len_o;
  logic [10:0] payload_o;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ilen_predec u_ilen_predec (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .esc_en_i(esc), .hw_i(hw),
    .valid_o(valid_o), .class_o(class_o), .len_o(len_o), .payload_o(payload_o)
  );

  task automatic check(input string tag, input bit ok, input string got, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %s exp %s", tag, got, exp);
    end
  endtask

  function automatic exp_t model(input logic v, input logic e, input logic [15:0] h);
    exp_t x;
    x.v = v; x.cls = '0; x.len = '0; x.pay = '0; x.tag = "R10";
    if (v) begin
      if (e && h[15:13] == 3'b000) begin
        x.pay = h[10:0];
        case (h[12:11])
          2'b00: begin x.cls = 5'b00001; x.len = 4'd2; x.tag = "R3 R9"; end
          2'b01: begin x.cls = 5'b00100; x.len = 4'd6; x.tag = "R4 R9"; end
          2'b10: begin x.cls = 5'b01000; x.len = 4'd8; x.tag = "R5 R9"; end
          default: begin x.cls = 5'b10000; x.len = 4'd0; x.tag = "R6 R9"; end
        endcase
      end else begin
        x.cls = 5'b00010; x.len = 4'd4;
        x.tag = e ? "R7 R9" : "R8 R9";
      end
    end
    return x;
  endfunction

  task automatic drive(input logic v, input logic e, input logic [15:0] h);
    @(negedge clk);
    valid = v; esc = e; hw = h;
    q.push_back(model(v, e, h));
  endtask

  // monitor: each posedge registers the item pushed at the preceding negedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        check({x.tag, " R2 valid"}, valid_o == x.v, $sformatf("%0b", valid_o), $sformatf("%0b", x.v));
        check({x.tag, " class"}, class_o == x.cls, $sformatf("%05b", class_o), $sformatf("%05b", x.cls));
        check({x.tag, " len"}, len_o == x.len, $sformatf("%0d", len_o), $sformatf("%0d", x.len));
        check({x.tag, " payload"}, payload_o == x.pay, $sformatf("%03h", payload_o), $sformatf("%03h", x.pay));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    check("R1 reset", {valid_o, class_o, len_o, payload_o} == '0,
          $sformatf("%0b/%05b/%0d/%03h", valid_o, class_o, len_o, payload_o), "0/00000/0/000");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 idle after reset", {valid_o, class_o, len_o, payload_o} == '0,
          $sformatf("%0b/%05b/%0d/%03h", valid_o, class_o, len_o, payload_o), "0/00000/0/000");
    // each selector pair, both members, escape on
    drive(1, 1, 16'h0000); // R3
    drive(1, 1, 16'h07FF); // R3 upper member
    drive(1, 1, 16'h0A5A); // R4
    drive(1, 1, 16'h1555); // R5
    drive(1, 1, 16'h1FFF); // R6
    drive(0, 1, 16'h0ABC); // R10 no strobe in escape row
    drive(1, 1, 16'h2123); // R7 first row out
    drive(1, 0, 16'h0800); // R8 escape off in row
    drive(0, 0, 16'hFFFF); // R10
    for (int op = 0; op < 64; op++) drive(1, 1, {op[5:0], 10'h2A5 ^ 10'(op * 37)});
    for (int op = 0; op < 64; op++) drive(1, 0, {op[5:0], 10'h15A ^ 10'(op * 11)});
    for (int i = 0; i < 16; i++) drive(i[0], 1'(i >> 1), 16'(i * 16'h1357));
    drive(0, 0, 16'h0000);
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule